// File: doc/BRIEF.md
# Serial Character Transmitter with Freeze

This block turns parallel characters into asynchronous serial frames. A producer hands characters to a short staging queue. A mover carries them one at a time into a transmit FIFO. A shift stage sends each character on the line, one bit per bit-rate tick. The FIFO capacity is chosen at run time from two parameterised lengths, short and long. Frames can optionally carry a parity bit and an address/data marker bit for multidrop links.

The freeze input pauses transmission without losing its place. While freeze is high, nothing new is carried from the staging queue into the FIFO. Characters already in the FIFO still go out. Once the FIFO is empty and the shifter is idle, the frozen status rises and the line rests at mark. When freeze is released, sending resumes with the next character still waiting in the staging queue.

Top module: `uart_frz_tx`

## Requirements
- R1: A frame is a start bit (0), then DATA_W data bits with the least significant bit first, then the parity bit if PARITY_EN=1 (parity over the data bits: odd when PARITY_ODD=1, even otherwise), then the address marker (`wr_addr_i` as written) if ADDR_BIT_EN=1, then one stop bit (1). Each bit is held from one `bit_tick_i` to the next. The line is 1 when no frame is being sent.
- R2: If another character is waiting in the FIFO when a stop bit ends, its start bit follows on the same tick, with no idle bit in between.
- R3: While `freeze_i` is high, no character moves from the staging queue into the FIFO. Queued characters are kept, so the queue fills and `wr_ready_o` falls.
- R4: Characters already in the FIFO when freeze rises are all transmitted in full.
- R5: `frozen_o` is high in the cycle after a clock edge at which freeze was high, the FIFO was empty and the shifter was idle. Otherwise it is low. While it is high, `txd_o` is 1.
- R6: With `fifo_long_i`=0 the FIFO holds at most SHORT_DEPTH characters (default 1). With `fifo_long_i`=1 it holds up to LONG_DEPTH (default 32). This sets how many characters a freeze drains.
- R7: After freeze is released, the remaining queued characters go out in write order, none lost or repeated.
- R8: A freeze pulse that ends before `frozen_o` rises leaves the character stream intact. Every written character is sent, in order, and `frozen_o` stays low.
- R9: `wr_ready_o` is high when the staging queue has fewer than QUEUE_DEPTH entries. A write offered while it is low is dropped and never sent.
- R10: After reset `txd_o`=1, `tx_busy_o`=0, `frozen_o`=0 and `wr_ready_o`=1.
- R11: `tx_busy_o` is high exactly while a frame is on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_tick_i | input | 1 | One-cycle pulse per bit period |
| wr_valid_i | input | 1 | Character write strobe |
| wr_data_i | input | DATA_W | Character to send |
| wr_addr_i | input | 1 | Address marker bit for the character |
| wr_ready_o | output | 1 | Staging queue can accept a write |
| freeze_i | input | 1 | Pause at a character boundary after draining the FIFO |
| fifo_long_i | input | 1 | 0: short FIFO, 1: long FIFO |
| txd_o | output | 1 | Serial line |
| tx_busy_o | output | 1 | Frame in progress |
| frozen_o | output | 1 | Freeze has taken hold and the line is quiet |

## Verification
The bench compares the line, the busy and frozen flags and the write-ready signal on every cycle against a queue-based model. It also checks a few targeted corner cases:
- It freezes with the short FIFO loaded while more characters wait in the queue. A design that ignored the depth select, or kept moving characters during freeze, would send more than one character before going quiet.
- The same test with the long FIFO and ten committed characters catches a design that stops early and strands committed data.
- A burst written with ticks stopped catches a missing idle gap, or an extra one, between frames.
- Overfilling the queue, and pulsing freeze mid-burst, expose dropped, duplicated or misordered characters on resume.

// File: rtl/uart_frz_pkg.sv
package uart_frz_pkg;

   // Line level of an idle asynchronous link (mark)
   localparam logic LINE_MARK  = 1'b1;
   // Level of the start bit (space)
   localparam logic LINE_SPACE = 1'b0;

   // Width of a counter that must hold values 0..n
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

   // Width of a pointer that must index 0..n-1
   function automatic int unsigned ptr_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/uart_frz_fifo.sv
module uart_frz_fifo
   import uart_frz_pkg::*;
#(
   parameter int unsigned WIDTH = 9,
   parameter int unsigned DEPTH = 4,
   parameter string       TAG   = "fifo"
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic                       push_i,
   input  logic [WIDTH-1:0]           din_i,
   input  logic                       pop_i,
   output logic [WIDTH-1:0]           dout_o,
   output logic [cnt_width(DEPTH)-1:0] count_o
);

   localparam int unsigned PW = ptr_width(DEPTH);
   localparam int unsigned CW = cnt_width(DEPTH);

   if (DEPTH < 1) begin : g_bad_depth
      $error("uart_frz_fifo %s: DEPTH must be at least 1", TAG);
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("uart_frz_fifo %s: WIDTH must be at least 1", TAG);
   end

   logic [WIDTH-1:0] mem_q [DEPTH];
   logic [PW-1:0]    wr_ptr_q, rd_ptr_q;
   logic [CW-1:0]    cnt_q;

   function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         cnt_q    <= '0;
      end else begin
         if (push_i) wr_ptr_q <= ptr_next(wr_ptr_q);
         if (pop_i)  rd_ptr_q <= ptr_next(rd_ptr_q);
         case ({push_i, pop_i})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   always_ff @(posedge clk_i) begin
      if (push_i) mem_q[wr_ptr_q] <= din_i;
   end

   assign dout_o  = mem_q[rd_ptr_q];
   assign count_o = cnt_q;

   AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q == CW'(DEPTH)) |-> !(push_i && !pop_i)); // R9
   AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q == '0) |-> !pop_i); // R4

endmodule

// File: rtl/uart_frz_shift.sv
module uart_frz_shift
   import uart_frz_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned PARITY_EN   = 0,
   parameter int unsigned PARITY_ODD  = 0,
   parameter int unsigned ADDR_BIT_EN = 0
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            tick_i,
   input  logic            avail_i,
   input  logic [DATA_W:0] ent_i,
   output logic            take_o,
   output logic            txd_o,
   output logic            busy_o
);

   localparam int unsigned FRAME_W = DATA_W + PARITY_EN + ADDR_BIT_EN + 2;
   localparam int unsigned LW      = ptr_width(FRAME_W);

   if (PARITY_EN > 1 || PARITY_ODD > 1 || ADDR_BIT_EN > 1) begin : g_bad_opt
      $error("uart_frz_shift: option parameters must be 0 or 1");
   end

   logic [DATA_W-1:0]  data;
   logic               par_bit;
   logic               addr_bit;
   logic [FRAME_W-1:0] frame;
   logic [FRAME_W-1:0] sh_q;
   logic [LW-1:0]      left_q;
   logic               busy_q;
   logic               last;

   assign data = ent_i[DATA_W-1:0];

   // Parity variant
   if (PARITY_EN != 0) begin : g_par
      if (PARITY_ODD != 0) begin : g_odd
         assign par_bit = ~^data;
      end else begin : g_even
         assign par_bit = ^data;
      end
   end else begin : g_nopar
      assign par_bit = LINE_MARK;   // lands on the stop position
   end

   // Address marker variant
   if (ADDR_BIT_EN != 0) begin : g_addr
      assign addr_bit = ent_i[DATA_W];
   end else begin : g_noaddr
      logic unused_addr;
      assign unused_addr = ent_i[DATA_W];
      assign addr_bit    = LINE_MARK; // lands on the stop position
   end

   always_comb begin
      frame                         = '1;
      frame[0]                      = LINE_SPACE;
      frame[DATA_W:1]               = data;
      frame[DATA_W+1]               = par_bit;
      frame[DATA_W+1+PARITY_EN]     = addr_bit;
   end

   assign last   = (left_q == '0);
   assign take_o = tick_i && avail_i && (!busy_q || last);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sh_q   <= '1;
         left_q <= '0;
         busy_q <= 1'b0;
      end else if (take_o) begin
         sh_q   <= frame;
         left_q <= LW'(FRAME_W - 1);
         busy_q <= 1'b1;
      end else if (tick_i && busy_q) begin
         if (last) begin
            sh_q   <= '1;
            busy_q <= 1'b0;
         end else begin
            sh_q   <= {LINE_MARK, sh_q[FRAME_W-1:1]};
            left_q <= left_q - 1'b1;
         end
      end
   end

   assign txd_o  = sh_q[0];
   assign busy_o = busy_q;

   AST_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(busy_q) |-> (txd_o == LINE_SPACE)); // R1
   AST_IDLE_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_q |-> (txd_o == LINE_MARK)); // R11
   AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i |=> $stable(txd_o)); // R1

endmodule

// File: rtl/uart_frz_tx.sv
module uart_frz_tx
   import uart_frz_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned PARITY_EN   = 0,
   parameter int unsigned PARITY_ODD  = 0,
   parameter int unsigned ADDR_BIT_EN = 0,
   parameter int unsigned QUEUE_DEPTH = 4,
   parameter int unsigned SHORT_DEPTH = 1,
   parameter int unsigned LONG_DEPTH  = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bit_tick_i,
   input  logic              wr_valid_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              wr_addr_i,
   output logic              wr_ready_o,
   input  logic              freeze_i,
   input  logic              fifo_long_i,
   output logic              txd_o,
   output logic              tx_busy_o,
   output logic              frozen_o
);

   localparam int unsigned ENT_W = DATA_W + 1;
   localparam int unsigned QCW   = cnt_width(QUEUE_DEPTH);
   localparam int unsigned FCW   = cnt_width(LONG_DEPTH);

   if (SHORT_DEPTH < 1 || SHORT_DEPTH > LONG_DEPTH) begin : g_bad_depths
      $error("uart_frz_tx: need 1 <= SHORT_DEPTH <= LONG_DEPTH");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("uart_frz_tx: DATA_W must be at least 1");
   end

   logic [ENT_W-1:0] q_dout, f_dout;
   logic [QCW-1:0]   q_cnt;
   logic [FCW-1:0]   f_cnt;
   logic [FCW-1:0]   cap;
   logic             q_push, move, take, sh_busy;
   logic             frozen_q;

   assign cap        = fifo_long_i ? FCW'(LONG_DEPTH) : FCW'(SHORT_DEPTH);
   assign wr_ready_o = (q_cnt < QCW'(QUEUE_DEPTH));
   assign q_push     = wr_valid_i && wr_ready_o;
   assign move       = !freeze_i && (q_cnt != '0) && (f_cnt < cap);

   uart_frz_fifo #(
      .WIDTH (ENT_W),
      .DEPTH (QUEUE_DEPTH),
      .TAG   ("stage")
   ) u_stage (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (q_push),
      .din_i   ({wr_addr_i, wr_data_i}),
      .pop_i   (move),
      .dout_o  (q_dout),
      .count_o (q_cnt)
   );

   uart_frz_fifo #(
      .WIDTH (ENT_W),
      .DEPTH (LONG_DEPTH),
      .TAG   ("txfifo")
   ) u_txfifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (move),
      .din_i   (q_dout),
      .pop_i   (take),
      .dout_o  (f_dout),
      .count_o (f_cnt)
   );

   uart_frz_shift #(
      .DATA_W      (DATA_W),
      .PARITY_EN   (PARITY_EN),
      .PARITY_ODD  (PARITY_ODD),
      .ADDR_BIT_EN (ADDR_BIT_EN)
   ) u_shift (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (bit_tick_i),
      .avail_i (f_cnt != '0),
      .ent_i   (f_dout),
      .take_o  (take),
      .txd_o   (txd_o),
      .busy_o  (sh_busy)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) frozen_q <= 1'b0;
      else         frozen_q <= freeze_i && (f_cnt == '0) && !sh_busy;
   end

   assign tx_busy_o = sh_busy;
   assign frozen_o  = frozen_q;

   AST_FREEZE_NO_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      freeze_i |=> (f_cnt <= $past(f_cnt))); // R3
   AST_FREEZE_KEEPS_QUEUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      freeze_i |=> (q_cnt >= $past(q_cnt))); // R3
   AST_FROZEN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frozen_o |-> (txd_o == LINE_MARK && !tx_busy_o)); // R5
   AST_SHORT_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!fifo_long_i && f_cnt <= FCW'(SHORT_DEPTH)) |=> (f_cnt <= FCW'(SHORT_DEPTH))); // R6

endmodule

// File: tb/uart_frz_tx_tb.sv
`timescale 1ns/1ps
module uart_frz_tx_tb;

   localparam int DW   = 8;
   localparam int PE   = 1;
   localparam int PO   = 1;
   localparam int AE   = 1;
   localparam int QD   = 4;
   localparam int SD   = 1;
   localparam int LD   = 32;
   localparam int FW   = DW + PE + AE + 2;
   localparam int TDIV = 4;
   localparam int FRAME_CYC = FW * TDIV;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bit_tick = 1'b0;
   logic          wr_valid = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          wr_addr = 1'b0;
   logic          wr_ready;
   logic          freeze = 1'b0;
   logic          fifo_long = 1'b1;
   logic          txd, busy, frozen;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit tick_en = 1'b0;
   int tick_ctr = 0;
   bit cmp_en = 1'b0;

   always #2.5 clk = ~clk;

   uart_frz_tx #(
      .DATA_W(DW), .PARITY_EN(PE), .PARITY_ODD(PO), .ADDR_BIT_EN(AE),
      .QUEUE_DEPTH(QD), .SHORT_DEPTH(SD), .LONG_DEPTH(LD)
   ) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .bit_tick_i(bit_tick),
      .wr_valid_i(wr_valid), .wr_data_i(wr_data), .wr_addr_i(wr_addr),
      .wr_ready_o(wr_ready), .freeze_i(freeze), .fifo_long_i(fifo_long),
      .txd_o(txd), .tx_busy_o(busy), .frozen_o(frozen)
   );

   // ---------------- reference model ----------------
   logic [DW:0]   mq [$];
   logic [DW:0]   mf [$];
   logic [FW-1:0] m_frame = '1;
   int            m_idx = 0;
   bit            m_busy = 0;
   bit            m_frozen = 0;
   int            m_loads = 0;
   int            oq, of_n, mcap;
   bit            ob, mv, fz_n;
   logic [DW:0]   ent;

   always @(posedge clk) begin
      if (!rst_n) begin
         mq.delete(); mf.delete();
         m_busy = 0; m_frozen = 0; m_idx = 0; m_frame = '1;
      end else begin
         oq   = mq.size();
         of_n = mf.size();
         ob   = m_busy;
         mcap = fifo_long ? LD : SD;
         mv   = !freeze && oq > 0 && of_n < mcap;
         fz_n = freeze && of_n == 0 && !ob;
         if (bit_tick) begin
            if (ob && m_idx < FW - 1) m_idx++;
            else if (of_n > 0) begin
               ent = mf.pop_front();
               m_frame = '1;
               m_frame[0] = 1'b0;
               m_frame[DW:1] = ent[DW-1:0];
               m_frame[DW+1] = PO ? ~^ent[DW-1:0] : ^ent[DW-1:0];
               m_frame[DW+2] = ent[DW];
               m_idx = 0; m_busy = 1; m_loads++;
            end else m_busy = 0;
         end
         if (mv) mf.push_back(mq.pop_front());
         if (wr_valid && oq < QD) mq.push_back({wr_addr, wr_data});
         m_frozen = fz_n;
      end
   end

   function automatic logic m_txd();
      return m_busy ? m_frame[m_idx] : 1'b1;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
      end
   endtask

   // Per-cycle comparison, sampled away from the active edge
   always @(negedge clk) begin
      if (cmp_en) begin
         check(txd == m_txd(), "R1 line", txd, m_txd());
         check(busy == m_busy, "R11 busy", busy, m_busy);
         check(frozen == m_frozen, "R5 frozen", frozen, m_frozen);
         check(wr_ready == (mq.size() < QD), "R9 ready", wr_ready, mq.size() < QD);
      end
   end

   // Bit-rate tick generator
   always @(negedge clk) begin
      bit_tick = tick_en && (tick_ctr == 0);
      tick_ctr = (tick_ctr + 1) % TDIV;
   end

   // Burst and freeze-pulse monitors
   int  busy_falls = 0;
   int  frozen_seen = 0;
   bit  prev_busy = 0;
   always @(negedge clk) begin
      if (prev_busy && !busy) busy_falls++;
      if (frozen) frozen_seen++;
      prev_busy = busy;
   end

   // Watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         fails++; checks++;
         $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic put(input logic [DW-1:0] d, input logic a);
      wr_valid = 1'b1; wr_data = d; wr_addr = a;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   int base;

   initial begin
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(1);
      // R10 reset state
      check(txd == 1'b1, "R10 txd", txd, 1);
      check(busy == 1'b0, "R10 busy", busy, 0);
      check(frozen == 1'b0, "R10 frozen", frozen, 0);
      check(wr_ready == 1'b1, "R10 ready", wr_ready, 1);
      cmp_en = 1'b1;

      // Burst with ticks stopped, then released: R1, R2
      fifo_long = 1'b1;
      base = m_loads;
      put(8'hA5, 1'b1); put(8'h3C, 1'b0); put(8'h00, 1'b1);
      wait_cyc(4);
      busy_falls = 0;
      tick_en = 1'b1;
      wait_cyc(3 * FRAME_CYC + 20);
      check(m_loads - base == 3, "R1 frames sent", m_loads - base, 3);
      check(busy_falls == 1, "R2 back-to-back", busy_falls, 1);

      // Overfill the queue while frozen: R9, R5, R7
      tick_en = 1'b0;
      freeze = 1'b1;
      base = m_loads;
      for (int i = 0; i < 6; i++) put(8'(8'h10 + i), i[0]);
      check(wr_ready == 1'b0, "R9 queue full", wr_ready, 0);
      wait_cyc(2);
      check(frozen == 1'b1, "R5 frozen idle", frozen, 1);
      freeze = 1'b0;
      tick_en = 1'b1;
      wait_cyc(4 * FRAME_CYC + 40);
      check(m_loads - base == 4, "R9 dropped writes", m_loads - base, 4);

      // Short FIFO freeze: R3, R4, R6, R7
      tick_en = 1'b0;
      fifo_long = 1'b0;
      base = m_loads;
      put(8'h81, 1'b0); put(8'h7E, 1'b1); put(8'hF0, 1'b0);
      wait_cyc(3);
      freeze = 1'b1;
      put(8'h0F, 1'b1); put(8'h55, 1'b0);
      check(wr_ready == 1'b0, "R3 queue kept", wr_ready, 0);
      tick_en = 1'b1;
      wait_cyc(3 * FRAME_CYC);
      check(m_loads - base == 1, "R6 short drain", m_loads - base, 1);
      check(frozen == 1'b1, "R4 drained then frozen", frozen, 1);
      check(txd == 1'b1, "R5 line idle", txd, 1);
      freeze = 1'b0;
      wait_cyc(5 * FRAME_CYC + 60);
      check(m_loads - base == 5, "R7 resume", m_loads - base, 5);
      check(frozen == 1'b0, "R7 unfrozen", frozen, 0);

      // Long FIFO freeze: R4, R6
      tick_en = 1'b0;
      fifo_long = 1'b1;
      base = m_loads;
      for (int i = 0; i < 10; i++) put(8'(8'hC3 ^ (i * 17)), i[1]);
      wait_cyc(4);
      freeze = 1'b1;
      tick_en = 1'b1;
      wait_cyc(10 * FRAME_CYC + 40);
      check(m_loads - base == 10, "R6 long drain", m_loads - base, 10);
      check(frozen == 1'b1, "R4 all drained", frozen, 1);
      freeze = 1'b0;
      wait_cyc(4);

      // Freeze pulse that never takes hold: R8
      base = m_loads;
      frozen_seen = 0;
      put(8'h11, 1'b0); put(8'h22, 1'b1); put(8'h33, 1'b0);
      wait_cyc(FRAME_CYC + 10);
      freeze = 1'b1;
      wait_cyc(1);
      freeze = 1'b0;
      wait_cyc(3 * FRAME_CYC + 40);
      check(m_loads - base == 3, "R8 stream intact", m_loads - base, 3);
      check(frozen_seen == 0, "R8 never frozen", frozen_seen, 0);
      check(txd == 1'b1 && busy == 1'b0, "R11 idle after", busy, 0);

      cmp_en = 1'b0;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule